// File: doc/BRIEF.md
# Prescaled Reloading Real-Time Counter

This block is a system timer that keeps counting while the rest of the chip sleeps. A 7-bit prescaler divides the chosen time base. Each time the prescaler wraps, a 16-bit down counter steps down by one. When both stages are at zero on a counting tick, the 16-bit stage takes the value of a programmable reload register and a sticky event flag is raised. The flag is offered as an interrupt request and as a wake-up request, and each has its own enable bit.

The time base is a per-cycle tick that comes either from the CPU clock or from the crystal oscillator. Both are modelled as clock enables in the one clock domain. When the crystal is itself driving the CPU, the crystal choice is overridden and the CPU tick is used. Software reaches the block through a small write port. Only the power-on reset input returns the block to its defaults. The ordinary system reset leaves counting, flag and settings alone, and it only blocks register writes while it is asserted.

Top module: `rt_sys_timer`

## Requirements
- R1: After power-on reset, flag, irq and wake are 0, the reload value is 0 and the control bits are all 0, so no flag appears while ticks arrive.
- R2: Once the counter is loaded with value V and counting starts, the flag rises on exactly the 128*(V+1)-th counting tick.
- R3: On the terminal tick the 16-bit stage reloads from the reload register and counting carries on without software action, so the next period is again 128*(V+1) ticks.
- R4: While the run bit (control bit 0) is 0, ticks are ignored and the count holds.
- R5: A write to the reload register (wr_addr=0, wr_data[15:0]) while run is 0 also loads the counter and restarts the prescaler from 127. While run is 1 it only stores the value, which takes effect at the next reload.
- R6: With control bit 1 set to 1 and xtal_is_cpu low, only xclk_en ticks count. With control bit 1 set to 0, only cclk_en ticks count.
- R7: When xtal_is_cpu is high, cclk_en is used as the tick even if control bit 1 is 1.
- R8: The flag is sticky. A control write (wr_addr=1) with wr_data[7]=1 clears it, and one with wr_data[7]=0 leaves it as it is. A clear in the same cycle as a terminal tick leaves the flag set.
- R9: irq equals the flag ANDed with control bit 2, and wake equals the flag ANDed with control bit 3.
- R10: While sys_rst_n is low, counting and the flag carry on and all register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| sys_rst_n | input | 1 | Ordinary system reset, active low; blocks writes only |
| cclk_en | input | 1 | CPU clock tick enable |
| xclk_en | input | 1 | Crystal clock tick enable |
| xtal_is_cpu | input | 1 | High when the crystal is driving the CPU clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = reload register, 1 = control register |
| wr_data | input | 16 | Write data |
| flag | output | 1 | Sticky terminal-count flag |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
The period is measured in counted ticks for several reload values: 2, 0 and 1. This separates the prescaler length from the counter length and shows the off-by-one at the reload. A changed reload is written in the middle of a running period, and a second load is done in the middle of a period while the counter is stopped. These tell an immediate load apart from a deferred one, and show whether the prescaler restarts. The tick source is switched between a steady CPU tick and a crystal tick that toggles every other cycle, and then again with the fallback condition set, so that a wrong mux choice gives a count that is too short or a timeout. A clear is timed to land on the terminal tick to show that the set takes priority.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  parameter int PRE_W = 7;
  parameter int CNT_W = 16;

  localparam int BIT_RUN  = 0;
  localparam int BIT_XSEL = 1;
  localparam int BIT_IRQ  = 2;
  localparam int BIT_WAKE = 3;
  localparam int BIT_CLR  = 7;

  typedef struct packed {
    logic wake_en;
    logic irq_en;
    logic xsel;
    logic run;
  } rtc_ctrl_t;
endpackage

// File: rtl/rtc_src_sel.sv
module rtc_src_sel (
  input  logic cclk_en,
  input  logic xclk_en,
  input  logic xtal_is_cpu,
  input  logic xsel,
  output logic tick
);
  logic use_xtal;

  always_comb begin
    use_xtal = xsel && !xtal_is_cpu;
    tick     = use_xtal ? xclk_en : cclk_en;
  end
endmodule

// File: rtl/rtc_chain.sv
module rtc_chain #(
  parameter int PRE_W = 7,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic             term
);
  localparam logic [PRE_W-1:0] PRE_TOP = {PRE_W{1'b1}};

  logic [PRE_W-1:0] presc_q, presc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    presc_d = presc_q;
    cnt_d   = cnt_q;
    term    = 1'b0;
    if (load) begin
      presc_d = PRE_TOP;
      cnt_d   = load_val;
    end else if (run && tick) begin
      if (presc_q == '0) begin
        presc_d = PRE_TOP;
        if (cnt_q == '0) begin
          cnt_d = reload_val;
          term  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else begin
        presc_d = presc_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= PRE_TOP;
      cnt_q   <= '0;
    end else begin
      presc_q <= presc_d;
      cnt_q   <= cnt_d;
    end
  end

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> cnt_q == $past(reload_val));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> ($stable(cnt_q) && $stable(presc_q)));

  assert_prescale_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !load && presc_q != '0) |=> presc_q == PRE_W'($past(presc_q) - 1'b1));
endmodule

// File: rtl/rtc_flag.sv
module rtc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  input  logic wake_en,
  output logic flag,
  output logic irq,
  output logic wake
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_comb begin
    flag = flag_q;
    irq  = flag_q && irq_en;
    wake = flag_q && wake_en;
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/rt_sys_timer.sv
module rt_sys_timer
  import rtc_pkg::*;
#(
  parameter int P_W = rtc_pkg::PRE_W,
  parameter int C_W = rtc_pkg::CNT_W
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           sys_rst_n,
  input  logic           cclk_en,
  input  logic           xclk_en,
  input  logic           xtal_is_cpu,
  input  logic           wr_en,
  input  logic           wr_addr,
  input  logic [C_W-1:0] wr_data,
  output logic           flag,
  output logic           irq,
  output logic           wake
);
  localparam logic ADDR_RELOAD = 1'b0;
  localparam logic ADDR_CTRL   = 1'b1;

  logic por_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      por_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      por_meta_q <= 1'b1;
      rst_sync_n <= por_meta_q;
    end
  end

  rtc_ctrl_t      ctrl_q, ctrl_d;
  logic [C_W-1:0] reload_q, reload_d;
  logic           wr_ok, wr_reload, wr_ctrl, do_load, clr_req;
  logic           tick, term;

  always_comb begin
    wr_ok     = wr_en && sys_rst_n;
    wr_reload = wr_ok && (wr_addr == ADDR_RELOAD);
    wr_ctrl   = wr_ok && (wr_addr == ADDR_CTRL);
    do_load   = wr_reload && !ctrl_q.run;
    clr_req   = wr_ctrl && wr_data[BIT_CLR];
    reload_d  = wr_reload ? wr_data : reload_q;
    ctrl_d    = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.run     = wr_data[BIT_RUN];
      ctrl_d.xsel    = wr_data[BIT_XSEL];
      ctrl_d.irq_en  = wr_data[BIT_IRQ];
      ctrl_d.wake_en = wr_data[BIT_WAKE];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
    end
  end

  rtc_src_sel u_src (
    .cclk_en     (cclk_en),
    .xclk_en     (xclk_en),
    .xtal_is_cpu (xtal_is_cpu),
    .xsel        (ctrl_q.xsel),
    .tick        (tick)
  );

  rtc_chain #(.PRE_W(P_W), .CNT_W(C_W)) u_chain (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick       (tick),
    .run        (ctrl_q.run),
    .load       (do_load),
    .load_val   (wr_data),
    .reload_val (reload_q),
    .term       (term)
  );

  rtc_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set     (term),
    .clr     (clr_req),
    .irq_en  (ctrl_q.irq_en),
    .wake_en (ctrl_q.wake_en),
    .flag    (flag),
    .irq     (irq),
    .wake    (wake)
  );

  assert_write_block_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !sys_rst_n) |=> ($stable(ctrl_q) && $stable(reload_q)));
endmodule

// File: tb/sim_rt_sys_timer.sv
`timescale 1ns/1ps
module sim_rt_sys_timer;
  logic        clk = 1'b0;
  logic        por_n, sys_rst_n, cclk_en, xclk_en, xtal_is_cpu;
  logic        wr_en, wr_addr;
  logic [15:0] wr_data;
  logic        flag, irq, wake;

  int checks = 0;
  int fails  = 0;
  int tk     = 0;
  int cyc    = 0;
  bit b_run  = 1'b0;
  bit b_sel  = 1'b0;
  bit xtog   = 1'b0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rt_sys_timer u0 (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .cclk_en(cclk_en),
    .xclk_en(xclk_en), .xtal_is_cpu(xtal_is_cpu), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .flag(flag), .irq(irq), .wake(wake)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    bit src;
    @(posedge clk);
    src = (b_sel && !xtal_is_cpu) ? xclk_en : cclk_en;
    if (b_run && src) tk++;
    if (wr_en && sys_rst_n && wr_addr) begin
      b_run = wr_data[0];
      b_sel = wr_data[1];
    end
    cyc++;
    @(negedge clk);
    if (xtog) xclk_en = ~xclk_en;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_flag(input int max);
    int n = 0;
    while (!flag && n < max) begin step(); n++; end
  endtask

  task automatic start_period(input logic [15:0] v, input logic [15:0] ctl);
    wr(1'b1, 16'h0080);
    wr(1'b0, v);
    tk = 0;
    wr(1'b1, ctl);
  endtask

  task automatic t_reset();
    chk("R1 flag after por", flag, 0);
    chk("R1 irq after por", irq, 0);
    chk("R1 wake after por", wake, 0);
    repeat (300) step();
    chk("R1 R4 no flag with default control", flag, 0);
  endtask

  task automatic t_period();
    start_period(16'd2, 16'h0001);
    wait_flag(2000);
    chk("R2 period ticks reload 2", tk, 384);
  endtask

  task automatic t_live_reload();
    tk = 0;
    wr(1'b0, 16'd0);
    wr(1'b1, 16'h0081);
    wait_flag(2000);
    chk("R3 R5 auto reload keeps old value", tk, 384);
    tk = 0;
    wr(1'b1, 16'h0081);
    wait_flag(2000);
    chk("R5 deferred reload value 0", tk, 128);
  endtask

  task automatic t_sticky();
    wr(1'b1, 16'h0001);
    repeat (40) step();
    chk("R8 flag sticky with bit7=0 write", flag, 1);
    wr(1'b1, 16'h0080);
    chk("R8 flag cleared by bit7", flag, 0);
  endtask

  task automatic t_midload();
    wr(1'b0, 16'd1);
    wr(1'b1, 16'h0001);
    repeat (50) step();
    wr(1'b1, 16'h0000);
    wr(1'b0, 16'd1);
    repeat (400) step();
    chk("R4 no flag while stopped", flag, 0);
    tk = 0;
    wr(1'b1, 16'h0001);
    wait_flag(2000);
    chk("R5 load while stopped restarts prescaler", tk, 256);
  endtask

  task automatic t_xtal();
    int c0;
    xtog = 1'b1;
    start_period(16'd1, 16'h0003);
    c0 = cyc;
    wait_flag(4000);
    chk("R6 crystal ticks", tk, 256);
    chk("R6 crystal slower than cpu", int'((cyc - c0) >= 500), 1);
    xtog = 1'b0;
    xclk_en = 1'b0;
  endtask

  task automatic t_fallback();
    xtal_is_cpu = 1'b1;
    xclk_en = 1'b0;
    start_period(16'd1, 16'h0003);
    wait_flag(2000);
    chk("R7 fallback to cpu tick", tk, 256);
    xtal_is_cpu = 1'b0;
  endtask

  task automatic t_setwins();
    start_period(16'd0, 16'h0001);
    while (tk < 127 && cyc < 100000) step();
    wr(1'b1, 16'h0081);
    chk("R8 set wins over clear", flag, 1);
    wr(1'b1, 16'h0080);
    chk("R8 later clear works", flag, 0);
  endtask

  task automatic t_outputs();
    start_period(16'd0, 16'h0001);
    wait_flag(2000);
    wr(1'b1, 16'h0004);
    chk("R9 irq with irq enable", irq, 1);
    chk("R9 wake off with irq enable only", wake, 0);
    wr(1'b1, 16'h0008);
    chk("R9 irq off with wake enable only", irq, 0);
    chk("R9 wake with wake enable", wake, 1);
    wr(1'b1, 16'h0000);
    chk("R9 both off", int'(irq | wake), 0);
    chk("R9 flag still set", flag, 1);
  endtask

  task automatic t_sysrst();
    start_period(16'd0, 16'h0001);
    sys_rst_n = 1'b0;
    wait_flag(2000);
    chk("R10 counting during system reset", tk, 128);
    wr(1'b1, 16'h0080);
    chk("R10 clear ignored in system reset", flag, 1);
    sys_rst_n = 1'b1;
    wr(1'b1, 16'h0080);
    chk("R10 clear accepted after release", flag, 0);
  endtask

  task automatic t_por();
    start_period(16'd0, 16'h0001);
    wait_flag(2000);
    por_n = 1'b0;
    step();
    step();
    por_n = 1'b1;
    b_run = 1'b0; b_sel = 1'b0;
    repeat (4) step();
    chk("R1 flag cleared by por", flag, 0);
    repeat (300) step();
    chk("R1 control cleared by por", flag, 0);
  endtask

  initial begin
    por_n = 1'b0; sys_rst_n = 1'b1; cclk_en = 1'b1; xclk_en = 1'b0;
    xtal_is_cpu = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
    @(negedge clk);
    step();
    step();
    por_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_period();
    t_live_reload();
    t_sticky();
    t_midload();
    t_xtal();
    t_fallback();
    t_setwins();
    t_outputs();
    t_sysrst();
    t_por();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule